// File: doc/BRIEF.md
# Chained Readout Sequencer for a Power-Cycled Front End

Each front-end chip holds a copy of this sequencer. It runs the chip through a fixed power cycle. It waits in idle, powers up the analog and threshold-DAC sections, and holds off acquisition until both sections have had their wake-up time. It then records events into a local store of fixed depth, waits for conversion to finish, and reads out. Every chip in a system gets the cycle-start, end-of-acquisition and conversion-done strobes together, so all chips acquire and convert in parallel.

Readout is serialised over one shared data line by a token. A chip drives the shared bus only after the token reaches it, and only while it is in its readout phase. It presents one word per stored event. Each word carries the chip's 8-bit identifier and the event's slot index. When its store is empty, the chip raises a one-cycle token pulse that starts the next chip in the chain. A chip that recorded nothing hands the token on one cycle after it arrives. The two wake-up waits are given as clock-cycle counts on input pins. The event store, converter and serialiser are reduced to handshake strobes.

Top module: `chain_readout_seq`

## Requirements
- R1: After synchronous active-high reset, `phase` is 0 (idle), and `bus_oe`, `tok_out`, `pwr_analog`, `pwr_dac` and `mem_full` are all low.
- R2: Phase codes are 0 idle, 1 wake, 2 acquire, 3 convert, 4 wait-for-token and 5 readout. `cycle_start` in idle moves the chip to wake. `pwr_analog` and `pwr_dac` are high in wake, acquire and convert, and low in every other phase.
- R3: The wake phase lasts max(`analog_wake`,`dac_wake`)+1 cycles, and then the chip enters acquire.
- R4: In acquire, each cycle with `trig_write` high stores one event. `trig_write` in any other phase stores nothing, and this shows up as the number of words read out.
- R5: The store holds 16 events. When it is full, `mem_full` is high, further triggers are dropped, and the chip leaves acquire for convert on the next cycle without waiting for `acq_end`.
- R6: `acq_end` moves a chip from acquire to convert, and `conv_done` moves it from convert to wait-for-token.
- R7: `tok_in` in wait-for-token with events stored puts the chip in readout on the next cycle. `bus_oe` is high only in readout. While it is high, `bus_data` = {chip_id[7:0], slot[3:0]}, and the slots go up from 0. While `bus_oe` is low, `bus_data` is 0.
- R8: `word_taken` in readout consumes the current word. In the cycle after the last word is consumed, the chip is idle, `bus_oe` is low and `tok_out` is high for exactly one cycle.
- R9: A chip with no stored events that gets `tok_in` in wait-for-token raises `tok_out` on the next cycle and never asserts `bus_oe`.
- R10: `tok_in` outside wait-for-token has no effect on the phase or on the bus.
- R11: In a chain where each `tok_out` feeds the next chip's `tok_in`, at most one chip has `bus_oe` high in any cycle, and the words appear in chain order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_id | input | 8 | Identifier placed in every readout word |
| analog_wake | input | 16 | Analog wake-up wait, in clock cycles |
| dac_wake | input | 16 | Threshold-DAC wake-up wait, in clock cycles |
| cycle_start | input | 1 | Starts a power cycle from idle |
| acq_end | input | 1 | Closes the acquisition window |
| trig_write | input | 1 | Stores one event during acquire |
| conv_done | input | 1 | Conversion complete |
| tok_in | input | 1 | Readout token from the previous chip |
| word_taken | input | 1 | Serialiser has consumed the bus word |
| phase | output | 3 | Current phase code |
| pwr_analog | output | 1 | Analog section power enable |
| pwr_dac | output | 1 | Threshold-DAC power enable |
| mem_full | output | 1 | Event store full |
| bus_oe | output | 1 | Shared-bus drive enable |
| bus_data | output | 12 | Readout word, zero when released |
| tok_out | output | 1 | Token pulse to the next chip |

## Verification
The checker assumes that `tok_in` is a single-cycle pulse and that it comes only from the previous chip's `tok_out` or from one pulse at the head of the chain. It also assumes that the shared strobes reach every chip in the same cycle. The bench follows both assumptions: it wires three instances into a chain, drives the common strobes onto all of them at once, and pulses the head token once per cycle. Stray pulses go only to the head chip, while that chip is still converting.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_WAKE = 3'd1,
        PH_ACQ  = 3'd2,
        PH_CONV = 3'd3,
        PH_WAIT = 3'd4,
        PH_READ = 3'd5
    } phase_e;

    // Analog and DAC sections draw power only around the measurement.
    function automatic logic section_powered(phase_e p);
        return (p == PH_WAKE) || (p == PH_ACQ) || (p == PH_CONV);
    endfunction

endpackage

// File: rtl/chain_wake_timer.sv
module chain_wake_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] analog_lim,
    input  logic [CNT_W-1:0] dac_lim,
    output logic             ready
);
    logic [CNT_W-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (rst || !run)
            elapsed <= '0;
        else if (elapsed != '1)
            elapsed <= elapsed + CNT_W'(1);
    end

    assign ready = run && (elapsed >= analog_lim) && (elapsed >= dac_lim);
endmodule

// File: rtl/chain_evt_store.sv
module chain_evt_store #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             rd_start,
    input  logic             rd_adv,
    output logic [CNT_W-1:0] count,
    output logic [IDX_W-1:0] slot,
    output logic             full,
    output logic             empty,
    output logic             last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            slot  <= '0;
        end else begin
            if (wr && !full)
                count <= count + CNT_W'(1);
            else if (rd_adv && !empty)
                count <= count - CNT_W'(1);
            if (rd_start)
                slot <= '0;
            else if (rd_adv && !empty)
                slot <= slot + IDX_W'(1);
        end
    end

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign last  = (count == CNT_W'(1));
endmodule

// File: rtl/chain_readout_seq.sv
module chain_readout_seq
    import chain_rd_pkg::*;
#(
    parameter int ID_W   = 8,
    parameter int DEPTH  = 16,
    parameter int WAKE_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH),
    localparam int WORD_W = ID_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   chip_id,
    input  logic [WAKE_W-1:0] analog_wake,
    input  logic [WAKE_W-1:0] dac_wake,
    input  logic              cycle_start,
    input  logic              acq_end,
    input  logic              trig_write,
    input  logic              conv_done,
    input  logic              tok_in,
    input  logic              word_taken,
    output logic [2:0]        phase,
    output logic              pwr_analog,
    output logic              pwr_dac,
    output logic              mem_full,
    output logic              bus_oe,
    output logic [WORD_W-1:0] bus_data,
    output logic              tok_out
);
    phase_e           st, st_nxt;
    logic             pass_nxt;
    logic             wake_ready;
    logic [CNT_W-1:0] ev_cnt;
    logic [IDX_W-1:0] rd_slot;
    logic             st_full, st_empty, st_last;

    chain_wake_timer #(.CNT_W(WAKE_W)) u_wake (
        .clk        (clk),
        .rst        (rst),
        .run        (st == PH_WAKE),
        .analog_lim (analog_wake),
        .dac_lim    (dac_wake),
        .ready      (wake_ready)
    );

    chain_evt_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr       ((st == PH_ACQ) && trig_write),
        .rd_start ((st == PH_WAIT) && tok_in),
        .rd_adv   ((st == PH_READ) && word_taken),
        .count    (ev_cnt),
        .slot     (rd_slot),
        .full     (st_full),
        .empty    (st_empty),
        .last     (st_last)
    );

    always_comb begin
        st_nxt   = st;
        pass_nxt = 1'b0;
        case (st)
            PH_IDLE: if (cycle_start) st_nxt = PH_WAKE;
            PH_WAKE: if (wake_ready) st_nxt = PH_ACQ;
            PH_ACQ:  if (acq_end || st_full) st_nxt = PH_CONV;
            PH_CONV: if (conv_done) st_nxt = PH_WAIT;
            PH_WAIT: if (tok_in) begin
                if (st_empty) begin
                    st_nxt   = PH_IDLE;
                    pass_nxt = 1'b1;
                end else begin
                    st_nxt = PH_READ;
                end
            end
            PH_READ: if (word_taken && st_last) begin
                st_nxt   = PH_IDLE;
                pass_nxt = 1'b1;
            end
            default: st_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= PH_IDLE;
            tok_out <= 1'b0;
        end else begin
            st      <= st_nxt;
            tok_out <= pass_nxt;
        end
    end

    assign phase      = st;
    assign pwr_analog = section_powered(st);
    assign pwr_dac    = section_powered(st);
    assign mem_full   = st_full;
    assign bus_oe     = (st == PH_READ);
    assign bus_data   = bus_oe ? {chip_id, rd_slot} : '0;
endmodule

// File: rtl/chain_readout_sva.sv
module chain_readout_sva #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       phase,
    input logic             tok_in,
    input logic             tok_out,
    input logic             bus_oe,
    input logic             pwr_analog,
    input logic             pwr_dac,
    input logic             mem_full,
    input logic [CNT_W-1:0] ev_cnt
);
    assert_power_window_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd0 || phase == 3'd4 || phase == 3'd5) |-> (!pwr_analog && !pwr_dac));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        ev_cnt <= CNT_W'(DEPTH));

    assert_full_ends_acq_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd2 && mem_full) |=> (phase == 3'd3));

    assert_oe_after_token_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> $past(tok_in));

    assert_oe_has_data_R7: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (ev_cnt != '0));

    assert_token_idle_R8: assert property (@(posedge clk) disable iff (rst)
        tok_out |-> (phase == 3'd0 && !bus_oe));

    assert_empty_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd4 && tok_in && ev_cnt == '0) |=> (tok_out && !bus_oe));

    assert_conv_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd3) |=> (phase == 3'd3 || phase == 3'd4));
endmodule

bind chain_readout_seq chain_readout_sva #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .phase      (phase),
    .tok_in     (tok_in),
    .tok_out    (tok_out),
    .bus_oe     (bus_oe),
    .pwr_analog (pwr_analog),
    .pwr_dac    (pwr_dac),
    .mem_full   (mem_full),
    .ev_cnt     (ev_cnt)
);

// File: tb/chain_readout_seq_tb_top.sv
module chain_readout_seq_tb_top;
    localparam int N = 3;
    localparam int W = 12;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst;
    logic [15:0] an, dn;
    logic cycle_start, acq_end, conv_done, start_tok, word_taken;
    logic [N-1:0] trig;
    logic [2:0]   ph [N];
    logic [W-1:0] bd [N];
    logic [N-1:0] pa, pd, full, oe, tok;
    logic [N:0]   tch;
    logic [W-1:0] bus;

    int tests = 0;
    int fails = 0;

    assign tch[0]   = start_tok;
    assign tch[N:1] = tok;

    for (genvar k = 0; k < N; k++) begin : g_chip
        chain_readout_seq dut_i (
            .clk(clk), .rst(rst), .chip_id(8'(8'hA0 + k)),
            .analog_wake(an), .dac_wake(dn),
            .cycle_start(cycle_start), .acq_end(acq_end),
            .trig_write(trig[k]), .conv_done(conv_done),
            .tok_in(tch[k]), .word_taken(word_taken),
            .phase(ph[k]), .pwr_analog(pa[k]), .pwr_dac(pd[k]),
            .mem_full(full[k]), .bus_oe(oe[k]), .bus_data(bd[k]),
            .tok_out(tok[k])
        );
    end

    always_comb begin
        bus = '0;
        for (int k = 0; k < N; k++) bus = bus | bd[k];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; cycle_start = 0; acq_end = 0; conv_done = 0;
        start_tok = 0; word_taken = 0; trig = '0; an = '0; dn = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int k = 0; k < N; k++) begin
            check(ph[k] == 3'd0, "R1", "phase after reset", int'(ph[k]), 0);
            check({oe[k], tok[k], pa[k], pd[k], full[k]} == 5'b0, "R1",
                  "outputs after reset", int'({oe[k], tok[k], pa[k], pd[k], full[k]}), 0);
        end
    endtask

    // Wake phase; chip 0 sees a trigger throughout, which must be dropped (R4).
    task automatic t_wake(input int a, input int d);
        int cnt = 0;
        int m = (a > d) ? a : d;
        an = 16'(a); dn = 16'(d); cycle_start = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0; trig[0] = 1'b1;
        check(ph[0] == 3'd1 && pa[0] && pd[0], "R2", "wake entry with power",
              int'({ph[0], pa[0], pd[0]}), 7);
        while (ph[0] == 3'd1 && cnt < 2000) begin
            cnt++;
            @(negedge clk);
        end
        trig[0] = 1'b0;
        check(cnt == m + 1, "R3", "wake length", cnt, m + 1);
        for (int k = 0; k < N; k++)
            check(ph[k] == 3'd2 && pa[k], "R3", "acquire after wake", int'(ph[k]), 2);
    endtask

    task automatic t_acq(input int n0, input int n1, input int n2,
                         input bit stray_tok);
        int n [N];
        int mx;
        n[0] = n0; n[1] = n1; n[2] = n2;
        mx = n0; if (n1 > mx) mx = n1; if (n2 > mx) mx = n2;
        for (int i = 0; i < mx; i++) begin
            for (int k = 0; k < N; k++) trig[k] = (i < n[k]);
            @(negedge clk);
        end
        trig = '0;
        @(negedge clk);
        if (n0 > 16) begin
            check(full[0] && ph[0] == 3'd3, "R5", "full store ends acquire",
                  int'({full[0], ph[0]}), 11);
        end else begin
            check(ph[0] == 3'd2 && !full[0], "R6", "still acquiring", int'(ph[0]), 2);
        end
        acq_end = 1'b1;
        @(negedge clk);
        acq_end = 1'b0;
        for (int k = 0; k < N; k++)
            check(ph[k] == 3'd3, "R6", "convert after acq_end", int'(ph[k]), 3);
        if (stray_tok) begin
            start_tok = 1'b1;
            @(negedge clk);
            start_tok = 1'b0;
            @(negedge clk);
            check(ph[0] == 3'd3 && oe == '0 && bus == '0, "R10",
                  "token ignored in convert", int'(ph[0]), 3);
        end
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        for (int k = 0; k < N; k++) begin
            check(ph[k] == 3'd4, "R6", "wait after conv_done", int'(ph[k]), 4);
            check(!pa[k] && !pd[k], "R2", "power off after convert",
                  int'({pa[k], pd[k]}), 0);
        end
    endtask

    task automatic t_read(input int n0, input int n1, input int n2);
        int n [N];
        int first_oe [N];
        int rise [N];
        int exp_k = 0;
        int exp_s = 0;
        int words = 0;
        int total;
        bit bad_ovl = 0, bad_word = 0, bad_rel = 0, bad_pwr = 0, bad_idle = 0;
        n[0] = n0; n[1] = n1; n[2] = n2;
        total = n0 + n1 + n2;
        for (int k = 0; k < N; k++) begin first_oe[k] = -1; rise[k] = -1; end
        word_taken = 1'b1;
        start_tok = 1'b1;
        for (int cyc = 1; cyc < 300 && rise[N-1] < 0; cyc++) begin
            @(negedge clk);
            start_tok = 1'b0;
            if ($countones(oe) > 1) bad_ovl = 1;
            if (pa != '0 || pd != '0) bad_pwr = 1;
            if (oe == '0 && bus != '0) bad_rel = 1;
            for (int k = 0; k < N; k++) begin
                if (oe[k] && first_oe[k] < 0) first_oe[k] = cyc;
                if (tok[k]) begin
                    if (rise[k] < 0) rise[k] = cyc;
                    if (ph[k] != 3'd0 || oe[k]) bad_idle = 1;
                end
            end
            if (oe != '0) begin
                while (exp_k < N && exp_s >= n[exp_k]) begin exp_k++; exp_s = 0; end
                if (exp_k >= N || bus != W'({8'(8'hA0 + exp_k), 4'(exp_s)})) bad_word = 1;
                exp_s++;
                words++;
            end
        end
        word_taken = 1'b0;
        check(!bad_ovl, "R11", "single bus driver", int'(bad_ovl), 0);
        check(!bad_word, "R11", "word order and content", int'(bad_word), 0);
        check(!bad_rel, "R7", "released bus reads zero", int'(bad_rel), 0);
        check(!bad_pwr, "R2", "power off in readout", int'(bad_pwr), 0);
        check(!bad_idle, "R8", "idle with token out", int'(bad_idle), 0);
        check(words == total, "R4", "words read out", words, total);
        for (int k = 0; k < N; k++) begin
            int prev = (k == 0) ? 0 : rise[k-1];
            if (n[k] == 0) begin
                check(rise[k] == prev + 1, "R9", "empty chip passes token", rise[k], prev + 1);
                check(first_oe[k] == -1, "R9", "empty chip never drives", first_oe[k], -1);
            end else begin
                check(first_oe[k] == prev + 1, "R7", "readout after token", first_oe[k], prev + 1);
                check(rise[k] == first_oe[k] + n[k], "R8", "token after last word",
                      rise[k], first_oe[k] + n[k]);
            end
        end
        @(negedge clk);
        for (int k = 0; k < N; k++)
            check(ph[k] == 3'd0 && !tok[k], "R8", "idle, token pulse ended",
                  int'({ph[k], tok[k]}), 0);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_wake(5, 12);
        t_acq(3, 0, 2, 1'b1);
        t_read(3, 0, 2);
        t_wake(20, 3);
        t_acq(20, 5, 1, 1'b0);
        t_read(16, 5, 1);
        t_wake(0, 0);
        t_acq(0, 0, 0, 1'b0);
        t_read(0, 0, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule